// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Frame Sequencer

This block sits between a byte-addressed bus and a byte-wide serial shifter. When a read or write arrives for one of several flash chip selects, it builds a complete flash command frame and sends it one byte at a time. A frame holds a command byte, three or four address bytes, optional dummy bytes and 1 to 4 data bytes. Each select has its own control word. That word picks one of four access modes, supplies the command byte and the dummy count, and holds a stop bit that drives the select line.

In the three automatic modes, one bus access lowers the select, runs the whole frame and raises the select again. In user mode the block adds no framing: bus bytes go straight to the shifter, and software drives the select line through the stop bit. A small register write port loads the control words, the per-select write enables, the extended-address flags, the dummy fill byte and the segment sizes. The bus handshake is valid/ready. Ready pulses for one cycle once the last data byte has completed.

Top module: `flash_frame_seq`

## Requirements
- R1: The control word mode field is bits 1:0, with 0 = read, 1 = fast read, 2 = write and 3 = user. A bus write in read or fast-read mode is dropped: no byte is shifted and the select is untouched. A bus read in write mode is dropped the same way and returns 0.
- R2: In read mode the command byte is always 0x03, whatever the command field (bits 23:16) holds. In fast-read and write modes the command field is sent.
- R3: Address bytes follow the command, most significant byte first. Four bytes are sent when the select's extended-address flag is set, otherwise three.
- R4: Only fast-read mode inserts dummy bytes. Their count is ({bit 14, bits 7:6}) × 8, halved when bit 28 is set. A count of 0 inserts none.
- R5: Every dummy byte equals the low 8 bits of the dummy fill register.
- R6: An access moves bus_len+1 data bytes (1 to 4). Write data goes out from bus_wdata[7:0] upward. Read data is packed little-endian: the first byte received lands in bus_rdata[7:0], and unused upper bytes read 0.
- R7: In the automatic modes the stop bit (bit 2) is cleared when the access is accepted and set after the last data byte. cs_n of each select always equals its stop bit.
- R8: A write in write or user mode is performed only when configuration bit 16+i is set for select i. Otherwise it is dropped.
- R9: Before it is sent, the access offset is reduced modulo 2^L, where L is the select's segment size field. An L of 32 or more leaves the offset unchanged.
- R10: User mode sends no command, address or dummy bytes. A write shifts its data bytes. A read shifts 0x00 for each byte and returns what comes back. cs_n stays equal to the stop bit as software wrote it.
- R11: sh_start is a one-cycle pulse, and a new byte starts only after sh_done for the previous one. bus_ready is a one-cycle pulse issued after the final byte has completed.
- R12: After reset every stop bit is set, so all cs_n are high. Segment sizes reset to SEG_LG_DEF, and bus_ready and sh_start are low.
- R13: Register port word addresses are: 0 = configuration, 1 = extended-address flags (bit i for select i), 2 = dummy fill, 4+i = control word of select i, 8+i = segment size field of select i (bits 5:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_write | input | 1 | 1 = write access |
| bus_sel | input | SW | Target chip select |
| bus_addr | input | AW | Byte offset within the select's window |
| bus_len | input | 2 | Data bytes minus one |
| bus_wdata | input | 32 | Write data, first byte in bits 7:0 |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| sh_start | output | 1 | Start one byte on the serial engine |
| sh_tx | output | 8 | Byte to send |
| sh_done | input | 1 | Serial engine finished the byte |
| sh_rx | input | 8 | Byte received, valid with sh_done |
| cs_n | output | NSEL | Active-low chip selects |

## Verification
The checks assume that the serial engine raises sh_done only while a byte is outstanding. They also assume that no register write lands while a frame is running, and that bus_sel always names an existing select. The bench's engine model answers each started byte after a fixed delay and never pulses sh_done on its own. Register writes are issued only between accesses, once bus_ready has been seen. Selects are limited to 0..NSEL-1.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        MD_READ  = 2'd0,
        MD_FAST  = 2'd1,
        MD_WRITE = 2'd2,
        MD_USER  = 2'd3
    } fmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_RESP
    } fstate_e;

    localparam int          STOP_POS     = 2;
    localparam int          WE_BASE      = 16;
    localparam logic [7:0]  SLOW_READ_OP = 8'h03;

    // Control word fields actually consumed by the sequencer
    typedef struct packed {
        logic       dual_io;   // bit 28
        logic [7:0] opcode;    // bits 23:16
        logic       dum_hi;    // bit 14
        logic [1:0] dum_lo;    // bits 7:6
        logic       stop;      // bit 2
        fmode_e     mode;      // bits 1:0
    } sel_ctrl_t;

    // Everything the byte engine needs for one access
    typedef struct packed {
        logic        auto_cs;
        logic        drop;
        fmode_e      mode;
        logic [7:0]  cmd;
        logic        four_byte;
        logic [5:0]  ndum;
        logic [31:0] addr;
    } plan_t;

    function automatic sel_ctrl_t unpack_ctrl(input logic [31:0] w);
        sel_ctrl_t c;
        c.dual_io = w[28];
        c.opcode  = w[23:16];
        c.dum_hi  = w[14];
        c.dum_lo  = w[7:6];
        c.stop    = w[STOP_POS];
        c.mode    = fmode_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [5:0] dummy_bytes(input sel_ctrl_t c);
        logic [5:0] n;
        n = {c.dum_hi, c.dum_lo, 3'b000};
        if (c.dual_io) n = n >> 1;
        return n;
    endfunction

    function automatic logic [31:0] seg_mask(input logic [5:0] lg);
        if (lg >= 6'd32) return 32'hFFFF_FFFF;
        return (32'h1 << lg[4:0]) - 32'h1;
    endfunction

endpackage

// File: rtl/fseq_regs.sv
module fseq_regs
    import flash_seq_pkg::*;
#(
    parameter int         NSEL       = 3,
    parameter int         SW         = 2,
    parameter logic [5:0] SEG_LG_DEF = 6'd24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             frame_begin,
    input  logic             frame_end,
    input  logic [SW-1:0]    frame_sel,
    output sel_ctrl_t        ctrl_o  [NSEL],
    output logic [5:0]       seglg_o [NSEL],
    output logic [NSEL-1:0]  wen_o,
    output logic [NSEL-1:0]  ext_o,
    output logic [7:0]       dummy_o,
    output logic [NSEL-1:0]  cs_n
);

    logic [NSEL-1:0] wen_q;
    logic [NSEL-1:0] ext_q;
    logic [7:0]      dummy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wen_q   <= '0;
            ext_q   <= '0;
            dummy_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == 4'd0) wen_q   <= reg_wdata[WE_BASE +: NSEL];
            if (reg_addr == 4'd1) ext_q   <= reg_wdata[NSEL-1:0];
            if (reg_addr == 4'd2) dummy_q <= reg_wdata[7:0];
        end
    end

    assign wen_o   = wen_q;
    assign ext_o   = ext_q;
    assign dummy_o = dummy_q;

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        sel_ctrl_t  ctrl_r;
        logic [5:0] seg_r;
        logic       mine;

        assign mine = (frame_sel == SW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_r      <= '0;
                ctrl_r.stop <= 1'b1;
                seg_r       <= SEG_LG_DEF;
            end else begin
                if (reg_we && reg_addr == 4'(4 + i))
                    ctrl_r <= unpack_ctrl(reg_wdata);
                else if (frame_begin && mine)
                    ctrl_r.stop <= 1'b0;
                else if (frame_end && mine)
                    ctrl_r.stop <= 1'b1;
                if (reg_we && reg_addr == 4'(8 + i))
                    seg_r <= reg_wdata[5:0];
            end
        end

        assign ctrl_o[i]  = ctrl_r;
        assign seglg_o[i] = seg_r;
        assign cs_n[i]    = ctrl_r.stop;
    end

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_begin && !reg_we) |=> !cs_n[$past(frame_sel)]);

    // R7
    stop_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !reg_we) |=> cs_n[$past(frame_sel)]);

endmodule

// File: rtl/fseq_plan.sv
module fseq_plan
    import flash_seq_pkg::*;
#(
    parameter int AW = 24
) (
    input  sel_ctrl_t      ctrl,
    input  logic           wen,
    input  logic           ext,
    input  logic [5:0]     seglg,
    input  logic           is_write,
    input  logic [AW-1:0]  offset,
    output plan_t          plan
);

    always_comb begin
        plan           = '0;
        plan.mode      = ctrl.mode;
        plan.auto_cs   = (ctrl.mode != MD_USER);
        plan.cmd       = (ctrl.mode == MD_READ) ? SLOW_READ_OP : ctrl.opcode;
        plan.four_byte = ext;
        plan.ndum      = (ctrl.mode == MD_FAST) ? dummy_bytes(ctrl) : 6'd0;
        plan.addr      = 32'(offset) & seg_mask(seglg);
        if (is_write)
            plan.drop = !wen || (ctrl.mode == MD_READ) || (ctrl.mode == MD_FAST);
        else
            plan.drop = (ctrl.mode == MD_WRITE);
    end

endmodule

// File: rtl/fseq_engine.sv
module fseq_engine
    import flash_seq_pkg::*;
#(
    parameter int SW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_valid,
    input  logic           bus_write,
    input  logic [SW-1:0]  bus_sel,
    input  logic [1:0]     bus_len,
    input  logic [31:0]    bus_wdata,
    input  plan_t          plan_i,
    input  logic [7:0]     dummy_data,
    output logic           bus_ready,
    output logic [31:0]    bus_rdata,
    output logic           sh_start,
    output logic [7:0]     sh_tx,
    input  logic           sh_done,
    input  logic [7:0]     sh_rx,
    output logic           frame_begin,
    output logic           frame_end,
    output logic [SW-1:0]  frame_sel
);

    fstate_e        st;
    plan_t          pl;
    logic           wr_q;
    logic [SW-1:0]  sel_q;
    logic [1:0]     len_q;
    logic [31:0]    wdat_q;
    logic [5:0]     cnt;
    logic [1:0]     idx;
    logic           pend;
    logic           accept;
    logic [7:0]     tx_next;

    assign accept      = (st == ST_IDLE) && bus_valid && !bus_ready;
    assign frame_begin = accept && plan_i.auto_cs && !plan_i.drop;
    assign frame_end   = (st == ST_DATA) && pend && sh_done && (idx == len_q) && pl.auto_cs;
    assign frame_sel   = accept ? bus_sel : sel_q;

    always_comb begin
        case (st)
            ST_CMD:   tx_next = pl.cmd;
            ST_ADDR:  tx_next = pl.addr[8*cnt[1:0] +: 8];
            ST_DUMMY: tx_next = dummy_data;
            default:  tx_next = wr_q ? wdat_q[8*idx +: 8] : 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            pl        <= '0;
            wr_q      <= 1'b0;
            sel_q     <= '0;
            len_q     <= '0;
            wdat_q    <= '0;
            cnt       <= '0;
            idx       <= '0;
            pend      <= 1'b0;
            sh_start  <= 1'b0;
            sh_tx     <= '0;
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            sh_start  <= 1'b0;
            bus_ready <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        pl        <= plan_i;
                        wr_q      <= bus_write;
                        sel_q     <= bus_sel;
                        len_q     <= bus_len;
                        wdat_q    <= bus_wdata;
                        bus_rdata <= '0;
                        idx       <= '0;
                        pend      <= 1'b0;
                        if (plan_i.drop)         st <= ST_RESP;
                        else if (plan_i.auto_cs) st <= ST_CMD;
                        else                     st <= ST_DATA;
                    end
                end
                ST_RESP: begin
                    bus_ready <= 1'b1;
                    st        <= ST_IDLE;
                end
                default: begin
                    if (!pend) begin
                        sh_start <= 1'b1;
                        sh_tx    <= tx_next;
                        pend     <= 1'b1;
                    end else if (sh_done) begin
                        pend <= 1'b0;
                        case (st)
                            ST_CMD: begin
                                st  <= ST_ADDR;
                                cnt <= pl.four_byte ? 6'd3 : 6'd2;
                            end
                            ST_ADDR: begin
                                if (cnt != 6'd0) begin
                                    cnt <= cnt - 6'd1;
                                end else if (pl.ndum != 6'd0) begin
                                    st  <= ST_DUMMY;
                                    cnt <= pl.ndum - 6'd1;
                                end else begin
                                    st <= ST_DATA;
                                end
                            end
                            ST_DUMMY: begin
                                if (cnt == 6'd0) st <= ST_DATA;
                                else             cnt <= cnt - 6'd1;
                            end
                            default: begin
                                if (!wr_q) bus_rdata[8*idx +: 8] <= sh_rx;
                                if (idx == len_q) st <= ST_RESP;
                                else              idx <= idx + 2'd1;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // R11
    sh_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sh_start |=> !sh_start);

    // R11
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !sh_done) |=> !sh_start);

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready);

    // R2
    read_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_start && st == ST_CMD && pl.mode == MD_READ) |-> (sh_tx == SLOW_READ_OP));

endmodule

// File: rtl/flash_frame_seq.sv
module flash_frame_seq
    import flash_seq_pkg::*;
#(
    parameter int         NSEL       = 3,
    parameter int         AW         = 24,
    parameter logic [5:0] SEG_LG_DEF = 6'd24,
    localparam int        SW         = (NSEL > 1) ? $clog2(NSEL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [SW-1:0]    bus_sel,
    input  logic [AW-1:0]    bus_addr,
    input  logic [1:0]       bus_len,
    input  logic [31:0]      bus_wdata,
    output logic             bus_ready,
    output logic [31:0]      bus_rdata,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output logic [NSEL-1:0]  cs_n
);

    sel_ctrl_t        ctrl_a  [NSEL];
    logic [5:0]       seglg_a [NSEL];
    logic [NSEL-1:0]  wen_v;
    logic [NSEL-1:0]  ext_v;
    logic [7:0]       dummy_v;
    logic             frame_begin;
    logic             frame_end;
    logic [SW-1:0]    frame_sel;
    plan_t            plan;

    fseq_regs #(.NSEL(NSEL), .SW(SW), .SEG_LG_DEF(SEG_LG_DEF)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .frame_begin (frame_begin),
        .frame_end   (frame_end),
        .frame_sel   (frame_sel),
        .ctrl_o      (ctrl_a),
        .seglg_o     (seglg_a),
        .wen_o       (wen_v),
        .ext_o       (ext_v),
        .dummy_o     (dummy_v),
        .cs_n        (cs_n)
    );

    fseq_plan #(.AW(AW)) u_plan (
        .ctrl     (ctrl_a[bus_sel]),
        .wen      (wen_v[bus_sel]),
        .ext      (ext_v[bus_sel]),
        .seglg    (seglg_a[bus_sel]),
        .is_write (bus_write),
        .offset   (bus_addr),
        .plan     (plan)
    );

    fseq_engine #(.SW(SW)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_sel     (bus_sel),
        .bus_len     (bus_len),
        .bus_wdata   (bus_wdata),
        .plan_i      (plan),
        .dummy_data  (dummy_v),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata),
        .sh_start    (sh_start),
        .sh_tx       (sh_tx),
        .sh_done     (sh_done),
        .sh_rx       (sh_rx),
        .frame_begin (frame_begin),
        .frame_end   (frame_end),
        .frame_sel   (frame_sel)
    );

endmodule

// File: tb/sim_flash_frame_seq.sv
module sim_flash_frame_seq;

    localparam int NSEL = 3;
    localparam int AW   = 24;
    localparam int SW   = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_we = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [SW-1:0]   bus_sel = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic [1:0]      bus_len = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_ready;
    logic [31:0]     bus_rdata;
    logic            sh_start;
    logic [7:0]      sh_tx;
    logic            sh_done = 1'b0;
    logic [7:0]      sh_rx = '0;
    logic [NSEL-1:0] cs_n;

    always #5 clk = ~clk;

    flash_frame_seq #(.NSEL(NSEL), .AW(AW), .SEG_LG_DEF(6'd24)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx), .cs_n(cs_n)
    );

    int checks = 0;
    int fails  = 0;
    bit over   = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Shadow of what software programmed
    logic [31:0]     m_ctrl [NSEL];
    logic [31:0]     m_cfg;
    logic [NSEL-1:0] m_ext;
    logic [7:0]      m_dum;
    int              m_lg   [NSEL];

    // Serial engine model: records bytes, answers after a fixed delay
    logic [7:0] rx_ctr = 8'h40;
    int         lat    = 0;
    bit         busy   = 0;
    logic [7:0] cap_q[$];
    int         cur_sel = 0;
    logic       exp_cs  = 1'b0;

    always @(negedge clk) begin
        sh_done = 1'b0;
        if (busy) begin
            if (lat == 0) begin
                sh_done = 1'b1;
                sh_rx   = rx_ctr;
                rx_ctr  = rx_ctr + 8'd1;
                busy    = 0;
            end else begin
                lat = lat - 1;
            end
        end else if (sh_start) begin
            cap_q.push_back(sh_tx);
            chk(cs_n[cur_sel] == exp_cs, "R7/R10 select level during byte", 32'(cs_n[cur_sel]), 32'(exp_cs));
            busy = 1;
            lat  = 1;
        end
    end

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        // R13 word map
        case (a)
            4'd0: m_cfg = d;
            4'd1: m_ext = d[NSEL-1:0];
            4'd2: m_dum = d[7:0];
            4'd4, 4'd5, 4'd6: m_ctrl[int'(a) - 4] = d;
            4'd8, 4'd9, 4'd10: m_lg[int'(a) - 8] = int'(d[5:0]);
            default: ;
        endcase
    endtask

    task automatic access(input bit wr, input int sel, input logic [AW-1:0] addr,
                          input int nbytes, input logic [31:0] wd, input string tag);
        logic [7:0]  exp_q[$];
        logic [31:0] c, a32, exp_rd;
        int          md, h, nd, guard;
        bit          drop, autocs;
        c      = m_ctrl[sel];
        md     = int'(c[1:0]);
        autocs = (md != 3);
        drop   = wr ? (!m_cfg[16 + sel] || md < 2) : (md == 2);
        a32    = 32'(addr);
        if (m_lg[sel] < 32) a32 = a32 % (32'd1 << m_lg[sel]);
        if (!drop && autocs) begin
            exp_q.push_back(md == 0 ? 8'h03 : c[23:16]);
            for (int k = (m_ext[sel] ? 3 : 2); k >= 0; k--) exp_q.push_back(a32[8*k +: 8]);
            if (md == 1) begin
                nd = (int'(c[14]) * 4 + int'(c[7:6])) * 8;
                if (c[28]) nd = nd / 2;
                for (int k = 0; k < nd; k++) exp_q.push_back(m_dum);
            end
        end
        h = exp_q.size();
        if (!drop) for (int k = 0; k < nbytes; k++) exp_q.push_back(wr ? wd[8*k +: 8] : 8'h00);
        exp_rd = '0;
        if (!drop && !wr) for (int k = 0; k < nbytes; k++) exp_rd[8*k +: 8] = rx_ctr + 8'(h + k);
        cur_sel = sel;
        exp_cs  = autocs ? 1'b0 : c[2];
        cap_q.delete();

        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_sel = SW'(sel); bus_addr = addr;
        bus_len = 2'(nbytes - 1); bus_wdata = wd;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!bus_ready && guard < 2000);
        chk(bus_ready, {tag, " R11 ready seen"}, 32'(bus_ready), 32'd1);
        if (!wr) chk(bus_rdata == exp_rd, {tag, " read data"}, bus_rdata, exp_rd);
        bus_valid = 1'b0;
        @(negedge clk);
        chk(cap_q.size() == exp_q.size(), {tag, " byte count"}, 32'(cap_q.size()), 32'(exp_q.size()));
        if (cap_q.size() == exp_q.size())
            for (int k = 0; k < exp_q.size(); k++)
                chk(cap_q[k] == exp_q[k], $sformatf("%s byte %0d", tag, k), 32'(cap_q[k]), 32'(exp_q[k]));
        if (!drop && autocs) m_ctrl[sel][2] = 1'b1;
        chk(cs_n[sel] == m_ctrl[sel][2], {tag, " R7 select after access"}, 32'(cs_n[sel]), 32'(m_ctrl[sel][2]));
    endtask

    initial begin
        #2000000;
        if (!over) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSEL; i++) begin m_ctrl[i] = 32'h4; m_lg[i] = 24; end
        m_cfg = '0; m_ext = '0; m_dum = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(cs_n == 3'b111, "R12 selects idle", 32'(cs_n), 32'h7);
        chk(!bus_ready && !sh_start, "R12 outputs quiet", {30'd0, bus_ready, sh_start}, 32'd0);

        // R2 R3 R6: read mode forces 0x03, three address bytes, 4 data bytes
        reg_wr(4'd4, 32'h00AB_0004);
        access(1'b0, 0, 24'h123456, 4, 32'h0, "R2 R6 read mode");
        // R3: extended address on select 0
        reg_wr(4'd1, 32'h1);
        access(1'b0, 0, 24'hABCDEF, 2, 32'h0, "R3 four-byte address");
        // R4 R5: fast read, 40 dummy bytes of 0xA5
        reg_wr(4'd2, 32'h0000_01A5);
        reg_wr(4'd5, 32'h000B_4045);
        access(1'b0, 1, 24'h000102, 1, 32'h0, "R4 R5 fast read");
        // R4: dual I/O halves 16 to 8
        reg_wr(4'd5, 32'h100B_0085);
        access(1'b0, 1, 24'h00FF00, 3, 32'h0, "R4 dual halving");
        // R4: zero dummy count
        reg_wr(4'd5, 32'h000B_0005);
        access(1'b0, 1, 24'h000010, 2, 32'h0, "R4 no dummies");
        // R8: write mode without enable is dropped
        reg_wr(4'd6, 32'h0002_0006);
        access(1'b1, 2, 24'h000200, 3, 32'h00C0_FFEE, "R8 write disabled");
        // R8 R6: write with enable, little-endian data order
        reg_wr(4'd0, 32'h0004_0000);
        access(1'b1, 2, 24'h000200, 3, 32'h00C0_FFEE, "R8 write enabled");
        // R1: read in write mode is dropped
        access(1'b0, 2, 24'h000300, 4, 32'h0, "R1 read in write mode");
        // R1: write in read mode is dropped even when enabled
        reg_wr(4'd0, 32'h0005_0000);
        access(1'b1, 0, 24'h000004, 1, 32'h0000_0077, "R1 write in read mode");
        // R9: 64 KiB segment wraps the offset
        reg_wr(4'd8, 32'd16);
        access(1'b0, 0, 24'h3A1234, 1, 32'h0, "R9 offset wrap");
        // R10: user mode, software-held select
        reg_wr(4'd5, 32'h0000_0003);
        @(negedge clk);
        chk(cs_n[1] == 1'b0, "R10 stop bit drives select low", 32'(cs_n[1]), 32'd0);
        reg_wr(4'd0, 32'h0007_0000);
        access(1'b1, 1, 24'h000000, 2, 32'h0000_9F06, "R10 user write");
        access(1'b0, 1, 24'h000000, 4, 32'h0, "R10 user read");
        reg_wr(4'd5, 32'h0000_0007);
        @(negedge clk);
        chk(cs_n[1] == 1'b1, "R10 stop bit releases select", 32'(cs_n[1]), 32'd1);
        // R7: software cleared stop bit, frame sets it again
        reg_wr(4'd4, 32'h0000_0000);
        @(negedge clk);
        chk(cs_n[0] == 1'b0, "R7 select low by software", 32'(cs_n[0]), 32'd0);
        access(1'b0, 0, 24'h000042, 1, 32'h0, "R7 stop restored");

        over = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule